// File: doc/BRIEF.md
# Fractional-N Divide Value Sequencer

This block works out, once per phase-comparison cycle, the whole-number divide value that a fractional-N feedback divider should use. Over time the mean of those values equals INT + (FRAC1 + FRAC2/MOD2)/2^FRAC1_W. The primary modulus is a fixed power of two, 2^24 by default. A programmable auxiliary modulus MOD2 adds an exact rational fine step, so channel spacings that do not divide a power of two are still hit exactly. For example, a 61.44 MHz comparison rate with 200 kHz spacing needs MOD2 = 61.44 MHz / GCD(61.44 MHz, 200 kHz) = 1536.

Two first-order accumulators are nested. The auxiliary one adds FRAC2 each step modulo MOD2, and its carry goes into the primary one. The primary one adds FRAC1 plus that carry modulo 2^FRAC1_W. The primary overflow bumps that step's divide value from INT to INT+1.

Software writes the four settings one at a time into shadow registers. None of them takes effect until a load strobe copies all four into the active set at once and restarts both accumulators. A clock enable at the comparison rate advances the sequence.

Top module: `fracn_divctl`

## Requirements
- R1: After reset, divVal is 0, all active settings are 0, and both accumulators are 0.
- R2: A write with wrEn high stores wrData into one shadow field. wrSel selects the field: 0 = INT, 1 = FRAC1, 2 = FRAC2, 3 = MOD2. Shadow writes leave the divide sequence unchanged until the next load.
- R3: On a loadStb edge, all shadow fields become active at once and both accumulators clear to 0. On that same edge divVal takes the new INT. The shadow contents used are those present before that edge.
- R4: Every divide value produced by a step is either INT or INT+1.
- R5: After k steps since the last load, with MOD2 in use, the sum of divVal over those steps equals k·INT + floor(k·(FRAC1·MOD2 + FRAC2) / (2^FRAC1_W·MOD2)).
- R6: Over exactly 2^FRAC1_W·MOD2 steps after a load, the sum equals INT·steps + FRAC1·MOD2 + FRAC2.
- R7: In a cycle where refEn and loadStb are both low, divVal and both accumulators hold their values.
- R8: If the loaded FRAC2 is not below the loaded MOD2 (this includes MOD2 = 0), the auxiliary accumulator stays at 0 and gives no carry. The sum after k steps is then k·INT + floor(k·FRAC1 / 2^FRAC1_W).
- R9: When loadStb and refEn are high in the same cycle, the load wins. No step is taken, and the first step happens at the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refEn | input | 1 | Comparison-rate step enable |
| wrEn | input | 1 | Shadow field write enable |
| wrSel | input | 2 | Shadow field select (0 INT, 1 FRAC1, 2 FRAC2, 3 MOD2) |
| wrData | input | DATA_W | Shadow write data, low bits used |
| loadStb | input | 1 | Copy shadow to active and restart accumulators |
| divVal | output | INT_W+1 | Divide value for the current comparison cycle |

## Verification
The hardest case to reach is the full repeat period of both accumulators together. Only there does the exact closing of the rational remainder show. At a 2^24 modulus it would take millions of steps. The bench therefore builds the block with a 6-bit primary modulus and a small MOD2, which brings the whole period down to a few hundred steps. It steps through each period completely and checks the running sum against the closed-form floor expression after every single step. The configurations include an auxiliary carry on nearly every step, a maximum INT whose INT+1 needs the extra output bit, and a disabled auxiliary path.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  typedef struct packed {
    logic clear;
    logic step;
  } fracnStrobe_t;

  typedef enum logic [1:0] {
    SEL_INT   = 2'd0,
    SEL_FRAC1 = 2'd1,
    SEL_FRAC2 = 2'd2,
    SEL_MOD2  = 2'd3
  } fieldSel_t;

endpackage

// File: rtl/fracn_ctrl.sv
module fracn_ctrl
  import fracn_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int FRAC1_W = 24,
  parameter int MOD2_W  = 14,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refEn,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               loadStb,
  output fracnStrobe_t       strobe,
  output logic [INT_W-1:0]   actInt,
  output logic [FRAC1_W-1:0] actFrac1,
  output logic [MOD2_W-1:0]  actFrac2,
  output logic [MOD2_W-1:0]  actMod2,
  output logic               auxOn,
  output logic [INT_W-1:0]   nextInt
);

  logic [INT_W-1:0]   shInt;
  logic [FRAC1_W-1:0] shFrac1;
  logic [MOD2_W-1:0]  shFrac2;
  logic [MOD2_W-1:0]  shMod2;
  fieldSel_t          selField;

  assign selField = fieldSel_t'(wrSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shInt   <= '0;
      shFrac1 <= '0;
      shFrac2 <= '0;
      shMod2  <= '0;
    end else if (wrEn) begin
      case (selField)
        SEL_INT:   shInt   <= wrData[INT_W-1:0];
        SEL_FRAC1: shFrac1 <= wrData[FRAC1_W-1:0];
        SEL_FRAC2: shFrac2 <= wrData[MOD2_W-1:0];
        default:   shMod2  <= wrData[MOD2_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actInt   <= '0;
      actFrac1 <= '0;
      actFrac2 <= '0;
      actMod2  <= '0;
      auxOn    <= 1'b0;
    end else if (loadStb) begin
      actInt   <= shInt;
      actFrac1 <= shFrac1;
      actFrac2 <= shFrac2;
      actMod2  <= shMod2;
      auxOn    <= (shFrac2 < shMod2);
    end
  end

  assign strobe.clear = loadStb;
  assign strobe.step  = refEn & ~loadStb;
  assign nextInt      = shInt;

  // R2
  cfgHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> $stable(actInt) && $stable(actFrac1) && $stable(actFrac2) && $stable(actMod2));

  // R9
  loadWins_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> !strobe.step && strobe.clear);

endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
  import fracn_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int FRAC1_W = 24,
  parameter int MOD2_W  = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  fracnStrobe_t       strobe,
  input  logic [INT_W-1:0]   actInt,
  input  logic [FRAC1_W-1:0] actFrac1,
  input  logic [MOD2_W-1:0]  actFrac2,
  input  logic [MOD2_W-1:0]  actMod2,
  input  logic               auxOn,
  input  logic [INT_W-1:0]   nextInt,
  output logic [INT_W:0]     divVal
);

  localparam int OUT_W = INT_W + 1;

  logic [MOD2_W-1:0]  auxAcc;
  logic [FRAC1_W-1:0] priAcc;
  logic [MOD2_W:0]    auxSum;
  logic               auxCarry;
  logic [MOD2_W-1:0]  auxNext;
  logic [FRAC1_W:0]   priSum;

  always_comb begin
    auxSum   = {1'b0, auxAcc} + {1'b0, actFrac2};
    auxCarry = auxOn && (auxSum >= {1'b0, actMod2});
    if (!auxOn)
      auxNext = '0;
    else if (auxCarry)
      auxNext = MOD2_W'(auxSum - {1'b0, actMod2});
    else
      auxNext = auxSum[MOD2_W-1:0];
    priSum = {1'b0, priAcc} + {1'b0, actFrac1} + (FRAC1_W+1)'(auxCarry);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      auxAcc <= '0;
      priAcc <= '0;
      divVal <= '0;
    end else if (strobe.clear) begin
      auxAcc <= '0;
      priAcc <= '0;
      divVal <= OUT_W'(nextInt);
    end else if (strobe.step) begin
      auxAcc <= auxNext;
      priAcc <= priSum[FRAC1_W-1:0];
      divVal <= OUT_W'(actInt) + OUT_W'(priSum[FRAC1_W]);
    end
  end

  // R4
  divRange_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (divVal == OUT_W'(actInt)) || (divVal == OUT_W'(actInt) + OUT_W'(1)));

  // R7
  idleHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step && !strobe.clear |=> $stable(divVal) && $stable(priAcc) && $stable(auxAcc));

  // R3
  clearAcc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (auxAcc == '0) && (priAcc == '0));

  // R8
  auxIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !auxOn |-> auxAcc == '0);

  // R5
  auxBound_chk: assert property (@(posedge clk) disable iff (!rstN)
    auxOn |-> auxAcc < actMod2);

endmodule

// File: rtl/fracn_divctl.sv
module fracn_divctl
  import fracn_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int FRAC1_W = 24,
  parameter int MOD2_W  = 14,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refEn,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadStb,
  output logic [INT_W:0]    divVal
);

  fracnStrobe_t       strobe;
  logic [INT_W-1:0]   actInt;
  logic [FRAC1_W-1:0] actFrac1;
  logic [MOD2_W-1:0]  actFrac2;
  logic [MOD2_W-1:0]  actMod2;
  logic               auxOn;
  logic [INT_W-1:0]   nextInt;

  fracn_ctrl #(
    .INT_W(INT_W), .FRAC1_W(FRAC1_W), .MOD2_W(MOD2_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .refEn(refEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .loadStb(loadStb), .strobe(strobe), .actInt(actInt),
    .actFrac1(actFrac1), .actFrac2(actFrac2), .actMod2(actMod2),
    .auxOn(auxOn), .nextInt(nextInt)
  );

  fracn_accum #(
    .INT_W(INT_W), .FRAC1_W(FRAC1_W), .MOD2_W(MOD2_W)
  ) u_accum (
    .clk(clk), .rstN(rstN), .strobe(strobe), .actInt(actInt),
    .actFrac1(actFrac1), .actFrac2(actFrac2), .actMod2(actMod2),
    .auxOn(auxOn), .nextInt(nextInt), .divVal(divVal)
  );

  // R1
  resetZero_chk: assert property (@(posedge clk)
    !rstN |=> divVal == '0);

endmodule

// File: tb/fracn_divctl_tb.sv
module fracn_divctl_tb;

  localparam int INT_W   = 8;
  localparam int FRAC1_W = 6;
  localparam int MOD2_W  = 4;
  localparam int DATA_W  = 16;
  localparam longint M1  = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              refEn = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrSel = 2'd0;
  logic [DATA_W-1:0] wrData = '0;
  logic              loadStb = 1'b0;
  logic [INT_W:0]    divVal;

  int     nChecks = 0;
  int     nFails  = 0;
  bit     done    = 1'b0;
  longint eInt, eF1, eF2, eM2;
  longint kSteps, cumSum;

  always #4 clk = ~clk;

  fracn_divctl #(
    .INT_W(INT_W), .FRAC1_W(FRAC1_W), .MOD2_W(MOD2_W), .DATA_W(DATA_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .refEn(refEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .loadStb(loadStb), .divVal(divVal)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expCum(input longint k);
    if (eF2 < eM2)
      return k * eInt + (k * (eF1 * eM2 + eF2)) / (M1 * eM2);
    return k * eInt + (k * eF1) / M1;
  endfunction

  task automatic wrField(input logic [1:0] sel, input longint val);
    wrEn = 1'b1; wrSel = sel; wrData = DATA_W'(val);
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setShadow(input longint i, input longint f1, input longint f2, input longint m2);
    wrField(2'd0, i); wrField(2'd1, f1); wrField(2'd2, f2); wrField(2'd3, m2);
  endtask

  task automatic doLoad(input bit withRef);
    loadStb = 1'b1; refEn = withRef;
    @(posedge clk); @(negedge clk);
    loadStb = 1'b0; refEn = 1'b0;
    kSteps = 0; cumSum = 0;
    check(divVal == (INT_W+1)'(eInt), "R3 load sets INT", longint'(divVal), eInt);
  endtask

  task automatic stepOnce(input string req);
    refEn = 1'b1;
    @(posedge clk); @(negedge clk);
    refEn = 1'b0;
    kSteps++;
    cumSum += longint'(divVal);
    if (!(longint'(divVal) == eInt || longint'(divVal) == eInt + 1))
      check(1'b0, "R4 divide value range", longint'(divVal), eInt);
    check(cumSum == expCum(kSteps), req, cumSum, expCum(kSteps));
  endtask

  task automatic runCfg(input longint i, input longint f1, input longint f2, input longint m2);
    longint period;
    eInt = i; eF1 = f1; eF2 = f2; eM2 = m2;
    setShadow(i, f1, f2, m2);
    doLoad(1'b0);
    period = (f2 < m2) ? M1 * m2 : M1;
    for (longint s = 0; s < period; s++)
      stepOnce((f2 < m2) ? "R5 running sum" : "R8 aux disabled sum");
    if (f2 < m2)
      check(cumSum == i * period + f1 * m2 + f2, "R6 full period sum", cumSum, i * period + f1 * m2 + f2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [INT_W:0] held;
    repeat (3) @(negedge clk);
    check(divVal == '0, "R1 reset value", longint'(divVal), 0);
    rstN = 1'b1;
    @(negedge clk);
    eInt = 0; eF1 = 0; eF2 = 0; eM2 = 0; kSteps = 0; cumSum = 0;
    stepOnce("R1 zero settings after reset");

    runCfg(68, 50, 2, 3);
    runCfg(255, 63, 12, 13);
    runCfg(10, 0, 0, 1);
    runCfg(3, 17, 5, 0);
    runCfg(20, 33, 15, 15);
    runCfg(7, 1, 14, 15);

    // R2: shadow writes mid-sequence leave the active sequence intact
    eInt = 40; eF1 = 21; eF2 = 3; eM2 = 7;
    setShadow(40, 21, 3, 7);
    doLoad(1'b0);
    for (int s = 0; s < 10; s++) stepOnce("R5 before shadow writes");
    setShadow(90, 5, 1, 2);
    for (int s = 0; s < 40; s++) stepOnce("R2 shadow writes ignored until load");

    // R7: idle cycles hold the output and the accumulator state
    held = divVal;
    repeat (6) @(negedge clk);
    check(divVal == held, "R7 idle hold", longint'(divVal), longint'(held));
    for (int s = 0; s < 20; s++) stepOnce("R7 sequence resumes unchanged");

    // R9: load together with refEn restarts without a step
    eInt = 90; eF1 = 5; eF2 = 1; eM2 = 2;
    doLoad(1'b1);
    for (int s = 0; s < 128; s++) stepOnce("R9 fresh sequence after load with refEn");
    check(cumSum == 90 * 128 + 5 * 2 + 1, "R9 R6 period after combined load", cumSum, 90 * 128 + 11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule